// File: doc/BRIEF.md
# PCI Shared Interrupt Line Router

This block steers eight shared PCI interrupt lines (numbered 0 to 7, grouped as 0-3 and 4-7) and one ACPI system control interrupt (SCI) onto 24 level-sensitive global interrupt outputs. Outputs 0 to 15 feed a legacy programmable interrupt controller. Outputs 16 to 23 feed an advanced interrupt controller.

Every shared line drives two outputs at the same time. Its fixed high output is `gsi_out[16+n]`. Its low output is chosen by a routing byte that software can program. The SCI is ORed onto one output taken from a sparse set of codes.

A table maps each (device slot, interrupt pin) pair to a shared line number. The rest of the chip looks a device's shared line up in this table. All outputs are combinational functions of the registered configuration and the live input levels, so they add no latency.

Top module: `pirq_router`

## Requirements
- R1: After reset, every routing byte reads 0x80 (low routing disabled), the SCI select reads code 0, and slot s pin i maps to line ((s+i) mod 4)+4.
- R2: For g in 0..15, `gsi_out[g]` is the OR of every line n whose routing byte has bit 7 clear and bits [4:0] equal to g.
- R3: A line is left off the low outputs when bit 7 of its routing byte is set, or when bits [4:0] hold 16 or more.
- R4: Line n always drives `gsi_out[16+n]`, whatever its routing byte holds, and no other line drives that output.
- R5: The SCI select uses bits [2:0]. Code 0 selects output 9, 1 selects 10, 2 selects 11, 4 selects 20 and 5 selects 21. Codes 3, 6 and 7 leave the SCI unrouted. The SCI level is ORed onto the selected output.
- R6: When the SCI select changes while the SCI is high, the old output falls and the new one rises in the same cycle. The SCI never shows on two outputs at once.
- R7: A write takes effect from the clock edge that samples it. Address 0-7 writes the routing byte of line 0-7, and address 8 writes the SCI select. Reading those addresses returns the stored values, with the select zero-extended.
- R8: Address 128+4s+i (bit 7 set, slot in bits [6:2], pin in bits [1:0]) writes the 3-bit line number held in data bits [2:0]. The map lookup port and the read port return that number.
- R9: Slot 30 is fixed: pin i maps to line 4+i. Its table entries read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pirq_lvl | input | 8 | Shared PCI interrupt line levels |
| sci_lvl | input | 1 | SCI level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data |
| map_slot | input | 5 | Device slot for map lookup |
| map_pin | input | 2 | Interrupt pin (0=INTA..3=INTD) for map lookup |
| map_pirq | output | 3 | Shared line number for that slot and pin |
| gsi_out | output | 24 | Global interrupt output levels |

## Verification
A fixed routing setup is used. It gives two lines the same low output, one line a disabled route, one line an out-of-range IRQ number, and the others distinct outputs, including the edges 0 and 15. Single-line patterns tell the shared-OR case apart from the disabled and out-of-range cases, and show the fixed high output stays on in each of them. Patterns that combine lines with the SCI show that the SCI merges onto output 9, which no line uses. The SCI select is then walked through every code with the SCI held high, which tells valid codes apart from reserved ones and shows each move drops the previous output. Map lookups cover the default formula, a rewritten entry, and the fixed slot.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NPIRQ = 8,
  parameter int NPIC  = 16,
  parameter int NSLOT = 32,
  parameter int FIXED_SLOT = 30,
  localparam int NGSI = NPIC + NPIRQ,
  localparam int LW   = $clog2(NPIRQ),
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIRQ-1:0] pirq_lvl,
  input  logic            sci_lvl,
  input  logic            wr_en,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      rd_addr,
  output logic [7:0]      rd_data,
  input  logic [SW-1:0]   map_slot,
  input  logic [1:0]      map_pin,
  output logic [LW-1:0]   map_pirq,
  output logic [NGSI-1:0] gsi_out
);

  logic [7:0]    route_q [NPIRQ];
  logic [2:0]    sci_sel_q;
  logic [LW-1:0] map_q [NSLOT][4];

  logic          wr_map;
  logic [SW-1:0] wr_slot;
  logic [SW-1:0] rd_slot;

  assign wr_map  = wr_en && wr_addr[7] && (wr_addr[6:2] != SW'(FIXED_SLOT));
  assign wr_slot = wr_addr[6:2];
  assign rd_slot = rd_addr[6:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NPIRQ; n++) route_q[n] <= 8'h80;
      sci_sel_q <= 3'd0;
      for (int s = 0; s < NSLOT; s++)
        for (int i = 0; i < 4; i++)
          map_q[s][i] <= LW'(((s + i) % 4) + 4);
    end else begin
      if (wr_en && wr_addr < 8'(NPIRQ)) route_q[wr_addr[LW-1:0]] <= wr_data;
      if (wr_en && wr_addr == 8'(NPIRQ)) sci_sel_q <= wr_data[2:0];
      if (wr_map) map_q[wr_slot][wr_addr[1:0]] <= wr_data[LW-1:0];
    end
  end

  logic [NPIC-1:0] pic_vec;
  always_comb begin
    pic_vec = '0;
    for (int n = 0; n < NPIRQ; n++)
      if (!route_q[n][7] && !route_q[n][4])
        pic_vec[route_q[n][3:0]] = pic_vec[route_q[n][3:0]] | pirq_lvl[n];
  end

  logic [NGSI-1:0] sci_vec;
  always_comb begin
    sci_vec = '0;
    case (sci_sel_q)
      3'd0: sci_vec[9]  = 1'b1;
      3'd1: sci_vec[10] = 1'b1;
      3'd2: sci_vec[11] = 1'b1;
      3'd4: sci_vec[20] = 1'b1;
      3'd5: sci_vec[21] = 1'b1;
      default: sci_vec = '0;
    endcase
  end

  assign gsi_out = {pirq_lvl, pic_vec} | (sci_lvl ? sci_vec : '0);

  assign map_pirq = (map_slot == SW'(FIXED_SLOT)) ? LW'(4 + map_pin)
                                                  : map_q[map_slot][map_pin];

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr[7]) begin
      if (rd_slot != SW'(FIXED_SLOT)) rd_data = 8'(map_q[rd_slot][rd_addr[1:0]]);
    end else if (rd_addr < 8'(NPIRQ)) begin
      rd_data = route_q[rd_addr[LW-1:0]];
    end else if (rd_addr == 8'(NPIRQ)) begin
      rd_data = {5'd0, sci_sel_q};
    end
  end

endmodule

module pirq_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  pirq_lvl,
  input logic        sci_lvl,
  input logic [7:0]  rd_addr,
  input logic [7:0]  rd_data,
  input logic [4:0]  map_slot,
  input logic [1:0]  map_pin,
  input logic [2:0]  map_pirq,
  input logic [23:0] gsi_out
);
  AST_APIC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_lvl & ~gsi_out[23:16]) == 8'h00); // R4
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_lvl == 8'h00 && !sci_lvl) |-> gsi_out == 24'h0); // R2
  AST_SCI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_lvl == 8'h00 && sci_lvl) |-> $countones(gsi_out) <= 1); // R6
  AST_SCI_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_lvl == 8'h00) |-> (gsi_out & ~24'h300E00) == 24'h0); // R5
  AST_FIXED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (map_slot == 5'd30) |-> map_pirq == 3'(4 + map_pin)); // R9
  AST_FIXED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[7] && rd_addr[6:2] == 5'd30) |-> rd_data == 8'h00); // R9
endmodule

bind pirq_router pirq_router_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
  .rd_addr(rd_addr), .rd_data(rd_data), .map_slot(map_slot),
  .map_pin(map_pin), .map_pirq(map_pirq), .gsi_out(gsi_out)
);

// File: tb/pirq_router_tb.sv
`timescale 1ns/100ps
module pirq_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pirq_lvl = 8'h00;
  logic sci_lvl = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h00, rd_data;
  logic [4:0] map_slot = 5'd0;
  logic [1:0] map_pin = 2'd0;
  logic [2:0] map_pirq;
  logic [23:0] gsi_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pirq_router dut_i (
    .clk(clk), .rst_n(rst_n), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .map_slot(map_slot),
    .map_pin(map_pin), .map_pirq(map_pirq), .gsi_out(gsi_out)
  );

  // {pirq, sci, expected gsi}
  localparam logic [32:0] VEC [12] = '{
    {8'h00, 1'b0, 24'h000000},
    {8'h01, 1'b0, 24'h010020},
    {8'h02, 1'b0, 24'h020020},
    {8'h04, 1'b0, 24'h040000},
    {8'h08, 1'b0, 24'h080000},
    {8'h10, 1'b0, 24'h100001},
    {8'h20, 1'b0, 24'h208000},
    {8'h40, 1'b0, 24'h400008},
    {8'h80, 1'b0, 24'h800000},
    {8'h00, 1'b1, 24'h000200},
    {8'h03, 1'b1, 24'h030220},
    {8'hFF, 1'b1, 24'hFF8229}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic lookup(input logic [4:0] s, input logic [1:0] p, output logic [2:0] v);
    map_slot = s; map_pin = p; #1; v = map_pirq;
  endtask

  task automatic drive(input logic [7:0] p, input logic s);
    @(negedge clk);
    pirq_lvl = p; sci_lvl = s; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [2:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int n = 0; n < 8; n++) begin
      rd(8'(n), r); chk("R1 route reset", 32'(r), 32'h80);
    end
    rd(8'd8, r); chk("R1 sci reset", 32'(r), 32'h0);
    lookup(5'd0, 2'd0, m); chk("R1 map s0p0", 32'(m), 32'd4);
    lookup(5'd1, 2'd3, m); chk("R1 map s1p3", 32'(m), 32'd4);
    lookup(5'd2, 2'd1, m); chk("R1 map s2p1", 32'(m), 32'd7);
    lookup(5'd31, 2'd2, m); chk("R1 map s31p2", 32'(m), 32'd5);
    drive(8'hFF, 1'b1); chk("R1 R3 all disabled", 32'(gsi_out), 32'hFF0200);
    drive(8'h00, 1'b0);

    // R7 configuration, checked by readback
    wr(8'd0, 8'h05); wr(8'd1, 8'h05); wr(8'd2, 8'h85); wr(8'd3, 8'h11);
    wr(8'd4, 8'h00); wr(8'd5, 8'h0F); wr(8'd6, 8'h03);
    rd(8'd5, r); chk("R7 route readback", 32'(r), 32'h0F);
    rd(8'd3, r); chk("R7 route readback", 32'(r), 32'h11);

    // R2 R3 R4 R5 vector table
    for (int k = 0; k < 12; k++) begin
      drive(VEC[k][32:25], VEC[k][24]);
      chk($sformatf("R2 R3 R4 vector %0d", k), 32'(gsi_out), 32'(VEC[k][23:0]));
    end

    // R5 R6 SCI steering with SCI held high
    drive(8'h00, 1'b1);
    wr(8'd8, 8'h04); #1; chk("R6 move to 20", 32'(gsi_out), 32'h100000);
    rd(8'd8, r); chk("R7 sci readback", 32'(r), 32'h04);
    wr(8'd8, 8'h01); #1; chk("R5 code1 -> 10", 32'(gsi_out), 32'h000400);
    wr(8'd8, 8'h02); #1; chk("R5 code2 -> 11", 32'(gsi_out), 32'h000800);
    wr(8'd8, 8'h05); #1; chk("R6 move to 21", 32'(gsi_out), 32'h200000);
    wr(8'd8, 8'h03); #1; chk("R5 code3 none", 32'(gsi_out), 32'h000000);
    wr(8'd8, 8'h06); #1; chk("R5 code6 none", 32'(gsi_out), 32'h000000);
    wr(8'd8, 8'h07); #1; chk("R5 code7 none", 32'(gsi_out), 32'h000000);
    wr(8'd8, 8'h00); #1; chk("R5 code0 -> 9", 32'(gsi_out), 32'h000200);
    drive(8'h00, 1'b0); chk("R5 sci low", 32'(gsi_out), 32'h000000);

    // R8 slot map writes
    wr(8'h80 | 8'(3*4+1), 8'h01);
    lookup(5'd3, 2'd1, m); chk("R8 map write", 32'(m), 32'd1);
    rd(8'h80 | 8'(3*4+1), r); chk("R8 map readback", 32'(r), 32'd1);
    lookup(5'd3, 2'd2, m); chk("R8 neighbour kept", 32'(m), 32'd5);

    // R9 fixed slot
    wr(8'h80 | 8'(30*4+2), 8'h01);
    for (int p = 0; p < 4; p++) begin
      lookup(5'd30, 2'(p), m); chk("R9 fixed slot map", 32'(m), 32'(4 + p));
      rd(8'h80 | 8'(30*4+p), r); chk("R9 fixed slot reads 0", 32'(r), 32'h0);
    end

    // R4 route byte has no effect on high output
    wr(8'd7, 8'h10);
    drive(8'h80, 1'b0); chk("R3 R4 field 16", 32'(gsi_out), 32'h800000);
    drive(8'h00, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule